// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block holds the interrupt control word of a multi-channel DMA controller. The word contains several kinds of field:

- per-channel enables;
- sticky per-channel completion flags;
- a global enable;
- a bus-error flag;
- a sent flag that records that an interrupt has already gone to the system interrupt controller.

Software writes the word over a 32-bit bus. The transfer engines report finished transfers with one-cycle pulses on `ch_done_i`.

Each write merges the data into the word:

- The plain control fields take the new data.
- The completion flags clear where a one is written and keep their value where a zero is written.

After every update the block re-evaluates the master condition. The condition holds when the global enable is set and at least one completion flag is set, or when the bus-error flag is set. While the condition holds, the sent flag is set.

When the sent flag rises from zero, the block pulses `irq_req_o` for one cycle. That line feeds source 3 of the system interrupt controller. No new pulse is issued while the sent flag stays set.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Reset (asynchronous, active low) clears all 32 bits of `reg_o` and drives `irq_req_o` low.
- R2: On a write, bits 5:0, bit 15 (bus error), bits 22:16 (channel enables) and bit 23 (global enable) take the written value at the next clock edge.
- R3: Bits 14:6 always read as zero, whatever value is written to them.
- R4: On a write, a one in bit 24+n clears completion flag n, and a zero leaves that flag unchanged.
- R5: A pulse on `ch_done_i[n]` sets flag bit 24+n only when enable bit 16+n is set, using the enable value that results from a write in the same cycle. With the enable clear, the pulse has no effect.
- R6: Without a write, completion flags never clear.
- R7: Bit 31 equals `(bit23 AND any of bits 30:24) OR bit15` after every update. It clears when that condition no longer holds.
- R8: `irq_req_o` is high for exactly one cycle: the first cycle in which bit 31 reads one after having read zero. It stays low while bit 31 remains set.
- R9: Written bit 31 is ignored. Bit 31 follows only from R7.
- R10: When a completion pulse and a clearing write hit the same flag in one cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| ch_done_i | input | 7 | Per-channel completion pulses |
| reg_o | output | 32 | Current register value |
| irq_req_o | output | 1 | One-cycle request to the system interrupt controller |

## Verification
Every internal field is visible on `reg_o` one cycle after the update that changes it, so a wrong flag, enable or sent bit shows at the ports within one clock edge. A sent flag that is wrong shows up in two ways: as a missing or repeated `irq_req_o` pulse on the same edge, or as a bit 31 that disagrees with the visible enable and flag fields. The stimulus covers a write and a completion pulse on the same cycle, pulses to disabled channels, and writes that try to set bit 31 or the reserved bits.

// File: rtl/dma_irq_ctrl_pkg.sv
package dma_irq_ctrl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned NUM_CH   = 7;
  localparam int unsigned RAW_W    = 6;   // plain storage bits 5:0
  localparam int unsigned BERR_BIT = 15;
  localparam int unsigned EN_LSB   = 16;
  localparam int unsigned GEN_BIT  = EN_LSB + NUM_CH;   // 23
  localparam int unsigned FLAG_LSB = GEN_BIT + 1;       // 24
  localparam int unsigned SENT_BIT = FLAG_LSB + NUM_CH; // 31
  localparam int unsigned RSV_LSB  = RAW_W;
  localparam int unsigned RSV_W    = BERR_BIT - RAW_W;

  typedef logic [NUM_CH-1:0] ch_vec_t;

  typedef struct packed {
    logic             gen;
    ch_vec_t          en;
    logic             berr;
    logic [RAW_W-1:0] raw;
  } ctrl_t;
endpackage

// File: rtl/dma_irq_ctrl_flags.sv
module dma_irq_ctrl_flags
  import dma_irq_ctrl_pkg::*;
#(
  parameter int unsigned N = NUM_CH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_nxt_i,
  input  logic [N-1:0] done_i,
  output logic [N-1:0] flags_q_o,
  output logic [N-1:0] flags_nxt_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic kept;
    logic flag_q;
    // set from a completion pulse wins over a same-cycle clear
    assign kept           = flag_q & ~(wr_en_i & clr_i[g]);
    assign flags_nxt_o[g] = kept | (done_i[g] & en_nxt_i[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flags_nxt_o[g];
    end
    assign flags_q_o[g] = flag_q;
  end
endmodule

// File: rtl/dma_irq_ctrl_master.sv
module dma_irq_ctrl_master
  import dma_irq_ctrl_pkg::*;
#(
  parameter int unsigned N = NUM_CH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gen_nxt_i,
  input  logic         berr_nxt_i,
  input  logic [N-1:0] flags_nxt_i,
  output logic         sent_o,
  output logic         req_o
);
  logic cond_nxt;
  logic sent_q;
  logic req_q;

  assign cond_nxt = (gen_nxt_i & (|flags_nxt_i)) | berr_nxt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      sent_q <= cond_nxt;
      req_q  <= cond_nxt & ~sent_q;
    end
  end

  assign sent_o = sent_q;
  assign req_o  = req_q;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] ch_done_i,
  output logic [REG_W-1:0]  reg_o,
  output logic              irq_req_o
);
  ctrl_t   ctrl_q, ctrl_nxt, ctrl_wr;
  ch_vec_t flags_q, flags_nxt;
  logic    sent;

  assign ctrl_wr.raw  = wr_data_i[RAW_W-1:0];
  assign ctrl_wr.berr = wr_data_i[BERR_BIT];
  assign ctrl_wr.en   = wr_data_i[EN_LSB +: NUM_CH];
  assign ctrl_wr.gen  = wr_data_i[GEN_BIT];
  assign ctrl_nxt     = wr_en_i ? ctrl_wr : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_nxt;
  end

  dma_irq_ctrl_flags #(.N(NUM_CH)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .clr_i       (wr_data_i[FLAG_LSB +: NUM_CH]),
    .en_nxt_i    (ctrl_nxt.en),
    .done_i      (ch_done_i),
    .flags_q_o   (flags_q),
    .flags_nxt_o (flags_nxt)
  );

  dma_irq_ctrl_master #(.N(NUM_CH)) u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gen_nxt_i   (ctrl_nxt.gen),
    .berr_nxt_i  (ctrl_nxt.berr),
    .flags_nxt_i (flags_nxt),
    .sent_o      (sent),
    .req_o       (irq_req_o)
  );

  assign reg_o = {sent, flags_q, ctrl_q.gen, ctrl_q.en, ctrl_q.berr,
                  {RSV_W{1'b0}}, ctrl_q.raw};
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] reg_o,
  input logic        irq_req_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_o[14:6] == 9'h0); // R3

  AST_SENT_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_o[31] == ((reg_o[23] && (|reg_o[30:24])) || reg_o[15])); // R7

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |=> !irq_req_o); // R8

  AST_REQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (reg_o[31] && !$past(reg_o[31]))); // R8

  AST_RISE_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_o[31]) |-> irq_req_o); // R8

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_o[30:24] & ~$past(reg_o[30:24]) & ~reg_o[22:16]) == 7'h0); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> ((reg_o[30:24] & $past(reg_o[30:24])) == $past(reg_o[30:24]))); // R6
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .reg_o     (reg_o),
  .irq_req_o (irq_req_o)
);

// File: tb/dma_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [6:0]  ch_done_i = '0;
  logic [31:0] reg_o;
  logic        irq_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_irq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ch_done_i(ch_done_i), .reg_o(reg_o), .irq_req_o(irq_req_o)
  );

  // {req tag, wr_en, wr_data, ch_done, expected reg, expected irq}
  localparam logic [76:0] VEC [NV] = '{
    {4'd2,  1'b1, 32'h0000_003F, 7'h00, 32'h0000_003F, 1'b0}, // R2 plain bits
    {4'd3,  1'b1, 32'hFFFF_FFC0, 7'h00, 32'h80FF_8000, 1'b1}, // R3 reserved zero, berr raises sent
    {4'd8,  1'b0, 32'h0000_0000, 7'h00, 32'h80FF_8000, 1'b0}, // R8 single pulse
    {4'd8,  1'b1, 32'h0000_8000, 7'h00, 32'h8000_8000, 1'b0}, // R8 no repeat while sent
    {4'd7,  1'b1, 32'h0000_0000, 7'h00, 32'h0000_0000, 1'b0}, // R7 sent clears
    {4'd2,  1'b1, 32'h0005_0000, 7'h00, 32'h0005_0000, 1'b0}, // R2 enables
    {4'd5,  1'b0, 32'h0000_0000, 7'h07, 32'h0505_0000, 1'b0}, // R5 ch1 disabled
    {4'd4,  1'b1, 32'h0085_0000, 7'h00, 32'h8585_0000, 1'b1}, // R4 zero keeps, R7 gen
    {4'd4,  1'b1, 32'h0185_0000, 7'h00, 32'h8485_0000, 1'b0}, // R4 clear ch0
    {4'd7,  1'b1, 32'h0485_0000, 7'h00, 32'h0085_0000, 1'b0}, // R7 last flag cleared
    {4'd5,  1'b0, 32'h0000_0000, 7'h04, 32'h8485_0000, 1'b1}, // R5 pulse sets, R8
    {4'd6,  1'b0, 32'h0000_0000, 7'h00, 32'h8485_0000, 1'b0}, // R6 sticky
    {4'd10, 1'b1, 32'h0485_0000, 7'h04, 32'h8485_0000, 1'b0}, // R10 set beats clear
    {4'd5,  1'b1, 32'h0780_0000, 7'h02, 32'h0080_0000, 1'b0}, // R5 enable off same cycle
    {4'd5,  1'b1, 32'h0082_0000, 7'h02, 32'h8282_0000, 1'b1}, // R5 enable on same cycle
    {4'd9,  1'b1, 32'h8000_0000, 7'h00, 32'h0200_0000, 1'b0}  // R9 written bit31 ignored
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check(1, "reset reg", reg_o, 32'h0);        // R1
    check(1, "reset irq", {31'h0, irq_req_o}, 32'h0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_en_i   = VEC[i][72];
      wr_data_i = VEC[i][71:40];
      ch_done_i = VEC[i][39:33];
      @(negedge clk_i);
      check(int'(VEC[i][76:73]), $sformatf("vec %0d reg", i), reg_o, VEC[i][32:1]);
      check(int'(VEC[i][76:73]), $sformatf("vec %0d irq", i), {31'h0, irq_req_o},
            {31'h0, VEC[i][0]});
      wr_en_i = 1'b0; ch_done_i = '0;
    end
    // R5: pulse on a disabled channel after idle leaves register unchanged
    ch_done_i = 7'h7D;
    @(negedge clk_i);
    ch_done_i = '0;
    check(5, "disabled pulses", reg_o, 32'h0200_0000);
    // R1: reset in mid-run with state set
    wr_en_i = 1'b1; wr_data_i = 32'h0000_8000;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check(7, "berr sets sent", reg_o, 32'h8200_8000);
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #(CLK_PERIOD/8);
    check(1, "async reset reg", reg_o, 32'h0);
    check(1, "async reset irq", {31'h0, irq_req_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: fresh rise after reset pulses again
    wr_en_i = 1'b1; wr_data_i = 32'h0000_8000;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check(8, "irq after reset", {31'h0, irq_req_o}, 32'h1);
    @(negedge clk_i);
    check(8, "irq drops", {31'h0, irq_req_o}, 32'h0);
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule